// File: doc/BRIEF.md
# Hardware Cursor Clip and Frame-Synchronous Commit

This block turns a signed cursor position, a cursor size and the active screen size into the on-screen cursor window that display hardware can use. On each axis it clips the cursor against the left/top and right/bottom edges of the screen. It reports where the visible part starts on screen and how far into the cursor bitmap that part begins. The same request also reports the bitmap row stride that a separate bitmap loader uses to copy the visible pixels.

The result is staged rather than applied at once. The staged window reaches the active cursor outputs only on the next frame-done pulse, so a cursor update never lands mid-frame. If the cursor cannot be seen, it is switched off at once. If the visible size changes, the cursor is also switched off at once and the loader is asked to reload the bitmap before the new window is committed.

Size requests are checked against the hardware limit. A request that breaks the limit is refused, and the current cursor state stays as it was.

Top module: `cursor_clip_commit`

## Requirements
- R1: With x < 0 the on-screen x is 0, the bitmap source x offset (src_x) is -x, and the visible width is the width minus min(-x, width).
- R2: With x + width above active_w the on-screen x is x and the visible width is max(active_w - x, 0); otherwise the visible width is the full width.
- R3: The vertical axis is clipped with the same rules against active_h, giving on-screen y, src_y and visible height.
- R4: With interlaced high, the on-screen y and the visible height are halved (rounding down), and src_stride is twice the cursor width instead of the width. src_y is not halved.
- R5: When no cursor is present, or the visible width or height is zero, the evaluation clears hw_en and fd_irq_en in the same clock edge, and nothing is committed later.
- R6: hw_pos packs y in bits 31:16 and x in bits 15:0. hw_size packs the visible height in bits 31:16 and the visible width in bits 15:0.
- R7: A visible evaluation stages a window and raises fd_irq_en. hw_pos, hw_size and hw_en take the staged values only on the edge where frame_done is sampled high while fd_irq_en is high, and fd_irq_en then drops.
- R8: When a visible evaluation yields a size different from the last staged size, hw_en clears in that edge and reload pulses for one cycle. An accepted set request that yields a visible cursor also pulses reload.
- R9: A set request with set_present high and both dimensions non-zero is refused if either dimension exceeds 64, or if both exceed 32. 64x32 and 32x64 are accepted.
- R10: A refused request raises size_err for exactly one cycle and changes neither the stored cursor size nor presence, nor the staged or active outputs.
- R11: After reset every output is zero.
- R12: A set or move request sampled at one edge is evaluated at the next edge. If an evaluation and frame_done coincide, the evaluation takes effect and that frame_done does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 1 | Request to load a new cursor shape |
| set_present | input | 1 | A cursor bitmap is assigned |
| set_w | input | 8 | Requested cursor width |
| set_h | input | 8 | Requested cursor height |
| move_req | input | 1 | Request to load a new position |
| move_x | input | 12 | Cursor x, two's complement |
| move_y | input | 12 | Cursor y, two's complement |
| active_w | input | 12 | Active screen width |
| active_h | input | 12 | Active screen height |
| interlaced | input | 1 | Interlaced timing in use |
| frame_done | input | 1 | End-of-frame pulse |
| size_err | output | 1 | Refused size request pulse |
| reload | output | 1 | Bitmap reload request pulse |
| src_x | output | 12 | Bitmap column where the visible part starts |
| src_y | output | 12 | Bitmap row where the visible part starts |
| src_stride | output | 9 | Bitmap row stride in pixels |
| fd_irq_en | output | 1 | A staged update waits for frame_done |
| hw_en | output | 1 | Active cursor enable |
| hw_pos | output | 32 | Active on-screen position |
| hw_size | output | 32 | Active visible size |

## Verification
The cursor is placed fully inside the screen and partly past each of the four edges, including positions where it vanishes entirely. This separates the offset-producing clip on the left and top from the width-limiting clip on the right and bottom. Moves that keep the size are mixed with moves that change the visible size, which distinguishes a plain restage from a disable-and-reload. Interlaced placements show that y and height are halved while the source row is not. Legal and refused sizes around 32 and 64, together with a frame_done that lands in the evaluation cycle, exercise the limit rule and the commit priority.

// File: rtl/cursor_clip_commit.sv
module cursor_clip_commit #(
  parameter int POS_W   = 12,
  parameter int DIM_W   = 8,
  parameter int MAX_DIM = 64,
  parameter int NARROW  = 32,
  parameter int FIELD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_req,
  input  logic                    set_present,
  input  logic [DIM_W-1:0]        set_w,
  input  logic [DIM_W-1:0]        set_h,
  input  logic                    move_req,
  input  logic signed [POS_W-1:0] move_x,
  input  logic signed [POS_W-1:0] move_y,
  input  logic [POS_W-1:0]        active_w,
  input  logic [POS_W-1:0]        active_h,
  input  logic                    interlaced,
  input  logic                    frame_done,
  output logic                    size_err,
  output logic                    reload,
  output logic [POS_W-1:0]        src_x,
  output logic [POS_W-1:0]        src_y,
  output logic [DIM_W:0]          src_stride,
  output logic                    fd_irq_en,
  output logic                    hw_en,
  output logic [2*FIELD_W-1:0]    hw_pos,
  output logic [2*FIELD_W-1:0]    hw_size
);
  localparam int PW = 2 * FIELD_W;
  localparam logic [DIM_W-1:0] MAXD = DIM_W'(MAX_DIM);
  localparam logic [DIM_W-1:0] NARD = DIM_W'(NARROW);

  logic signed [POS_W-1:0] cx, cy;
  logic [DIM_W-1:0] cw, ch;
  logic present, eval_q, from_set;
  logic [PW-1:0] stg_pos, stg_size;

  function automatic logic [3*POS_W-1:0] clip_axis(input logic signed [POS_W-1:0] p,
                                                   input logic [DIM_W-1:0] d,
                                                   input logic [POS_W-1:0] a);
    int pi, di, ai, scr, off, vis;
    pi = int'(p);
    di = int'(d);
    ai = int'(a);
    if (pi < 0) begin
      scr = 0; off = -pi;
      vis = di - ((off < di) ? off : di);
    end else if (pi + di > ai) begin
      scr = pi; off = 0;
      vis = (ai > pi) ? ai - pi : 0;
    end else begin
      scr = pi; off = 0; vis = di;
    end
    return {POS_W'(scr), POS_W'(off), POS_W'(vis)};
  endfunction

  wire [3*POS_W-1:0] xc = clip_axis(cx, cw, active_w);
  wire [3*POS_W-1:0] yc = clip_axis(cy, ch, active_h);
  wire [POS_W-1:0] xs = xc[3*POS_W-1:2*POS_W];
  wire [POS_W-1:0] xo = xc[2*POS_W-1:POS_W];
  wire [POS_W-1:0] xv = xc[POS_W-1:0];
  wire [POS_W-1:0] ys = interlaced ? (yc[3*POS_W-1:2*POS_W] >> 1) : yc[3*POS_W-1:2*POS_W];
  wire [POS_W-1:0] yo = yc[2*POS_W-1:POS_W];
  wire [POS_W-1:0] yv = interlaced ? (yc[POS_W-1:0] >> 1) : yc[POS_W-1:0];

  wire [PW-1:0] new_pos  = {FIELD_W'(ys), FIELD_W'(xs)};
  wire [PW-1:0] new_size = {FIELD_W'(yv), FIELD_W'(xv)};
  wire visible = present && (xv != '0) && (yv != '0);
  wire resized = new_size != stg_size;

  wire too_big = set_present && (set_w != '0) && (set_h != '0) &&
                 ((set_w > MAXD) || (set_h > MAXD) || ((set_w > NARD) && (set_h > NARD)));
  wire set_ok = set_req && !too_big;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx <= '0; cy <= '0; cw <= '0; ch <= '0; present <= 1'b0;
      eval_q <= 1'b0; from_set <= 1'b0;
      stg_pos <= '0; stg_size <= '0;
      size_err <= 1'b0; reload <= 1'b0;
      src_x <= '0; src_y <= '0; src_stride <= '0;
      fd_irq_en <= 1'b0; hw_en <= 1'b0; hw_pos <= '0; hw_size <= '0;
    end else begin
      size_err <= set_req && too_big;
      reload   <= 1'b0;
      eval_q   <= set_ok || move_req;
      from_set <= set_ok;
      if (set_ok) begin
        present <= set_present; cw <= set_w; ch <= set_h;
      end
      if (move_req) begin
        cx <= move_x; cy <= move_y;
      end
      if (eval_q) begin
        if (!visible) begin
          hw_en <= 1'b0; fd_irq_en <= 1'b0;
        end else begin
          if (resized) hw_en <= 1'b0;
          reload     <= from_set || resized;
          stg_pos    <= new_pos;
          stg_size   <= new_size;
          fd_irq_en  <= 1'b1;
          src_x      <= xo;
          src_y      <= yo;
          src_stride <= interlaced ? {cw, 1'b0} : {1'b0, cw};
        end
      end else if (frame_done && fd_irq_en) begin
        hw_pos <= stg_pos; hw_size <= stg_size; hw_en <= 1'b1; fd_irq_en <= 1'b0;
      end
    end
  end

  // R7
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_en) |-> ($past(frame_done) && $past(fd_irq_en)));
  // R7
  pos_only_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hw_pos) |-> $past(frame_done));
  // R5
  hidden_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_q && !visible) |=> (!hw_en && !fd_irq_en));
  // R8
  resize_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_q && visible && resized) |=> (!hw_en && reload));
  // R9
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |-> (hw_size[FIELD_W-1:0] <= FIELD_W'(MAX_DIM) && hw_size[PW-1:FIELD_W] <= FIELD_W'(MAX_DIM)));
  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> ($stable(cw) && $stable(ch) && $stable(present) && $past(set_req)));
endmodule

// File: tb/cursor_clip_commit_tb.sv
module cursor_clip_commit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_req = 0, set_present = 0, move_req = 0, interlaced = 0, frame_done = 0;
  logic [7:0] set_w = 0, set_h = 0;
  logic signed [11:0] move_x = 0, move_y = 0;
  logic [11:0] active_w = 12'd640, active_h = 12'd480;
  logic size_err, reload, fd_irq_en, hw_en;
  logic [11:0] src_x, src_y;
  logic [8:0] src_stride;
  logic [31:0] hw_pos, hw_size;

  int checks = 0, fails = 0, cycles = 0;

  cursor_clip_commit u_dut (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_present(set_present),
    .set_w(set_w), .set_h(set_h), .move_req(move_req), .move_x(move_x), .move_y(move_y),
    .active_w(active_w), .active_h(active_h), .interlaced(interlaced), .frame_done(frame_done),
    .size_err(size_err), .reload(reload), .src_x(src_x), .src_y(src_y),
    .src_stride(src_stride), .fd_irq_en(fd_irq_en), .hw_en(hw_en),
    .hw_pos(hw_pos), .hw_size(hw_size));

  always #5 clk = ~clk;

  // behavioural reference
  int m_cx, m_cy, m_cw, m_ch, m_pres, m_eval, m_fset, m_pend, m_en, m_pos, m_size;
  int m_spos, m_ssize, m_err, m_rel, m_sx, m_sy, m_str;

  task automatic clip_ref(input int p, input int d, input int a, output int s, output int o, output int v);
    if (p < 0) begin s = 0; o = -p; v = (o >= d) ? 0 : d - o; end
    else if (p + d > a) begin s = p; o = 0; v = (a - p > 0) ? a - p : 0; end
    else begin s = p; o = 0; v = d; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cx = 0; m_cy = 0; m_cw = 0; m_ch = 0; m_pres = 0; m_eval = 0; m_fset = 0;
      m_pend = 0; m_en = 0; m_pos = 0; m_size = 0; m_spos = 0; m_ssize = 0;
      m_err = 0; m_rel = 0; m_sx = 0; m_sy = 0; m_str = 0;
    end else begin
      int xs, xo, xv, ys, yo, yv, ns;
      bit big, ok;
      m_rel = 0;
      if (m_eval != 0) begin
        clip_ref(m_cx, m_cw, int'(active_w), xs, xo, xv);
        clip_ref(m_cy, m_ch, int'(active_h), ys, yo, yv);
        if (interlaced) begin ys = ys / 2; yv = yv / 2; end
        if (m_pres == 0 || xv == 0 || yv == 0) begin
          m_en = 0; m_pend = 0;
        end else begin
          ns = yv * 65536 + xv;
          if (ns != m_ssize) m_en = 0;
          m_rel = (m_fset != 0 || ns != m_ssize) ? 1 : 0;
          m_ssize = ns; m_spos = ys * 65536 + xs; m_pend = 1;
          m_sx = xo; m_sy = yo; m_str = interlaced ? 2 * m_cw : m_cw;
        end
      end else if (frame_done && m_pend != 0) begin
        m_pos = m_spos; m_size = m_ssize; m_en = 1; m_pend = 0;
      end
      big = set_present && set_w != 0 && set_h != 0 &&
            (set_w > 64 || set_h > 64 || (set_w > 32 && set_h > 32));
      ok = set_req && !big;
      m_err = (set_req && big) ? 1 : 0;
      m_eval = (ok || move_req) ? 1 : 0;
      m_fset = ok ? 1 : 0;
      if (ok) begin m_pres = set_present; m_cw = int'(set_w); m_ch = int'(set_h); end
      if (move_req) begin m_cx = int'(move_x); m_cy = int'(move_y); end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      cmp("R6 hw_pos", int'(hw_pos), m_pos);
      cmp("R2 hw_size", int'(hw_size), m_size);
      cmp("R7 hw_en", int'(hw_en), m_en);
      cmp("R5 fd_irq_en", int'(fd_irq_en), m_pend);
      cmp("R10 size_err", int'(size_err), m_err);
      cmp("R8 reload", int'(reload), m_rel);
      cmp("R1 src_x", int'(src_x), m_sx);
      cmp("R3 src_y", int'(src_y), m_sy);
      cmp("R4 src_stride", int'(src_stride), m_str);
    end
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic do_set(input bit p, input int w, input int h);
    @(negedge clk); set_req = 1; set_present = p; set_w = 8'(w); set_h = 8'(h);
    @(negedge clk); set_req = 0;
  endtask
  task automatic do_move(input int x, input int y);
    @(negedge clk); move_req = 1; move_x = 12'(x); move_y = 12'(y);
    @(negedge clk); move_req = 0;
  endtask
  task automatic do_fd();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R11 reset state
    cmp("R11 reset", int'(hw_en) + int'(fd_irq_en) + int'(reload) + int'(size_err) + int'(hw_pos != 0) + int'(hw_size != 0), 0);
    do_set(1, 16, 16); do_move(100, 50); do_fd();           // R7 plain commit
    do_move(120, 60); do_fd();                               // R7 same-size restage
    do_move(-5, 10); do_fd();                                // R1 left clip
    do_move(-20, 10); do_fd();                               // R5 vanishes left
    do_move(630, 470); do_fd();                              // R2 R3 right and bottom
    do_move(700, 10); do_fd();                               // R2 vanishes right
    do_move(10, -3); do_fd();                                // R3 top clip
    do_move(10, -16); do_fd();                               // R5 vanishes top
    interlaced = 1;
    do_move(10, 21); do_fd();                                // R4 interlace halving
    do_move(10, -5); do_fd();                                // R4 with top clip
    interlaced = 0;
    do_set(1, 64, 32); do_fd();                              // R9 legal wide
    do_set(1, 32, 64); do_fd();                              // R9 legal tall
    do_set(1, 64, 64); do_fd();                              // R9 R10 refused
    do_set(1, 65, 1); do_fd();                               // R9 refused width
    do_set(1, 33, 33); do_fd();                              // R9 refused both
    do_set(1, 33, 32); do_fd();                              // R9 legal boundary
    do_set(0, 16, 16); do_fd();                              // R5 no cursor
    do_set(1, 8, 8); do_fd();
    // R12 evaluation beside frame_done
    do_move(200, 200);
    @(negedge clk); move_req = 1; move_x = 12'(300); move_y = 12'(5); frame_done = 0;
    @(negedge clk); move_req = 0; frame_done = 1;
    @(negedge clk); frame_done = 0;
    do_fd();
    // R12 set and move together
    @(negedge clk); set_req = 1; set_present = 1; set_w = 8'd20; set_h = 8'd10;
    move_req = 1; move_x = 12'(635); move_y = 12'(0);
    @(negedge clk); set_req = 0; move_req = 0;
    do_fd();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule